// File: doc/BRIEF.md
# Asynchronous Serial Frame Transmitter

This block turns a parallel character into an asynchronous serial frame on one output line. A one-deep holding register sits in front of a frame shift register, so software or a DMA-like master can post the next character while the current one is still on the line. Bit timing comes from an external oversampling tick that pulses once per sixteenth of a bit, so the half-bit needed for a one-and-a-half stop length falls on a tick boundary.

Static inputs choose an 8- or 9-bit word, turn parity on or off, pick even or odd parity, and set the stop length. The word length counts the parity bit when parity is on. The shift register captures these settings when it loads a frame. When the enable input rises, the block first sends one idle frame, with the line high for a whole frame length, and only then takes a waiting character. Two flags report the state of the transmitter: one shows that the holding register can take a write, and the other shows that the line has gone quiet after the last stop bit.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset the line is high (mark), the holding register reads empty, the complete flag is 1 and the collision flag is 0. While the complete flag is 1 the line is high.
- R2: A frame is one low start bit, then the word bits least significant first. The word is 9 bits when `word9`=1 and 8 bits when `word9`=0. Each bit lasts 16 ticks of `os_tick`.
- R3: With `par_en`=1, the last word bit position carries parity in place of the top data bit. The parity covers the data bits below it: even (`par_odd`=0) makes the total count of ones even, and odd (`par_odd`=1) makes it odd.
- R4: `stop_sel` sets the stop length with the line high: 00 gives 16 ticks, 10 gives 32, 11 gives 24. The reserved code 01 behaves as 00.
- R5: When `tx_en` rises, the line stays high for a full frame length, (1 + word bits) x 16 ticks plus the stop length. The complete flag is 0 during that time. A character that is already waiting starts exactly when this idle frame ends.
- R6: An accepted write clears `hold_empty` on the next cycle. The flag sets again on the cycle the character moves into the shift register, which is also the cycle the start bit begins.
- R7: The complete flag rises on the tick that ends the last stop bit, and only if no character is waiting. If one is waiting, its start bit follows with no gap and the flag stays 0.
- R8: A write while the holding register is full is dropped and never sent. It sets `wr_collide`, which stays 1 until `clr_collide` is pulsed. A new collision in the same cycle wins over the clear.
- R9: While `tx_en`=0 the line is high and nothing is sent. A character already written stays in the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling enable, 16 pulses per bit time |
| tx_en | input | 1 | Transmitter enable; a rising edge sends an idle frame |
| word9 | input | 1 | 1: 9-bit word, 0: 8-bit word (parity included) |
| par_en | input | 1 | Parity on |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| stop_sel | input | 2 | Stop length code (00 one, 10 two, 11 one and a half, 01 as 00) |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Character to send |
| clr_collide | input | 1 | Clears the collision flag |
| tx_line | output | 1 | Serial output, idles high |
| hold_empty | output | 1 | Holding register can accept a write |
| tx_done | output | 1 | Transmission complete |
| wr_collide | output | 1 | Sticky flag for a write dropped while full |

## Verification
The bench sweeps all 32 combinations of word length, parity enable, parity sense and stop code. Each combination starts with an idle-frame check and then sends two characters back to back. The data patterns change from one combination to the next, so that both parity senses see odd and even counts of ones. Sampling every bit at its centre and timing the rise of the complete flag to the exact tick separates 8-bit from 9-bit framing, parity from plain data, and the three stop lengths. The check at the end of the first frame of each pair separates a gapless second start bit from a wrongly asserted complete flag. A character written before enabling shows whether the idle frame is honoured, and a write into a full register shows that a dropped character never reaches the line.

// File: rtl/sfx_pkg.sv
package sfx_pkg;

   typedef enum logic [1:0] {
      ST_OFF   = 2'd0,
      ST_IDLE  = 2'd1,
      ST_SHIFT = 2'd2,
      ST_STOP  = 2'd3
   } sfx_state_e;

   localparam logic [1:0] STOP_ONE     = 2'b00;
   localparam logic [1:0] STOP_RSVD    = 2'b01;
   localparam logic [1:0] STOP_TWO     = 2'b10;
   localparam logic [1:0] STOP_ONEHALF = 2'b11;

endpackage

// File: rtl/sfx_hold.sv
module sfx_hold #(
   parameter int DATA_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              take,
   input  logic              clr_collide,
   output logic              full,
   output logic [DATA_W-1:0] data,
   output logic              collide
);

   logic accept;
   logic reject;

   assign accept = wr_valid && !full;
   assign reject = wr_valid && full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full    <= 1'b0;
         data    <= '0;
         collide <= 1'b0;
      end else begin
         if (accept) begin
            full <= 1'b1;
            data <= wr_data;
         end else if (take) begin
            full <= 1'b0;
         end
         if (reject) begin
            collide <= 1'b1;
         end else if (clr_collide) begin
            collide <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/sfx_framer.sv
module sfx_framer
   import sfx_pkg::*;
#(
   parameter int DATA_W = 9,
   parameter int OSR    = 16,
   parameter int FW     = DATA_W + 1,
   parameter int TW     = $clog2(2 * OSR + 1),
   parameter int BCW    = $clog2(FW + 1)
) (
   input  logic [DATA_W-1:0] data,
   input  logic              word9,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic [1:0]        stop_sel,
   output logic [FW-1:0]     frame,
   output logic [BCW-1:0]    nbits,
   output logic [TW-1:0]     stop_ticks
);

   localparam int HALF = OSR / 2;

   logic [BCW-1:0]    nword;
   logic [DATA_W-1:0] below_top;
   logic [DATA_W-1:0] at_top;
   logic [DATA_W-1:0] word_bits;
   logic              par_bit;

   assign nword = word9 ? BCW'(DATA_W) : BCW'(DATA_W - 1);
   assign nbits = nword + BCW'(1);

   for (genvar i = 0; i < DATA_W; i++) begin : g_pos
      assign below_top[i] = (BCW'(i + 1) < nword);
      assign at_top[i]    = (BCW'(i + 1) == nword);
      always_comb begin
         if (at_top[i] && par_en) begin
            word_bits[i] = par_bit;
         end else if (below_top[i] || at_top[i]) begin
            word_bits[i] = data[i];
         end else begin
            word_bits[i] = 1'b1;
         end
      end
   end

   assign par_bit = par_odd ^ (^(data & below_top));
   assign frame   = {word_bits, 1'b0};

   always_comb begin
      unique case (stop_sel)
         STOP_TWO:     stop_ticks = TW'(2 * OSR);
         STOP_ONEHALF: stop_ticks = TW'(OSR + HALF);
         STOP_RSVD:    stop_ticks = TW'(OSR);
         default:      stop_ticks = TW'(OSR);
      endcase
   end

endmodule

// File: rtl/sfx_seq.sv
module sfx_seq
   import sfx_pkg::*;
#(
   parameter int OSR = 16,
   parameter int FW  = 10,
   parameter int TW  = $clog2(2 * OSR + 1),
   parameter int BCW = $clog2(FW + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           os_tick,
   input  logic           tx_en,
   input  logic           hold_full,
   input  logic [FW-1:0]  frame,
   input  logic [BCW-1:0] nbits,
   input  logic [TW-1:0]  stop_ticks,
   output logic           take,
   output logic           tx_line,
   output logic           tx_done
);

   sfx_state_e     state;
   logic [FW-1:0]  shreg;
   logic [TW-1:0]  tick_cnt;
   logic [BCW-1:0] bits_left;
   logic [TW-1:0]  stop_len;
   logic           bit_end;
   logic           stop_end;

   assign bit_end  = os_tick && (tick_cnt == TW'(OSR - 1));
   assign stop_end = os_tick && (tick_cnt == stop_len - TW'(1));
   assign take     = tx_en && hold_full &&
                     ((state == ST_IDLE) || ((state == ST_STOP) && stop_end));
   assign tx_line  = (state == ST_SHIFT) ? shreg[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_OFF;
         shreg     <= '1;
         tick_cnt  <= '0;
         bits_left <= '0;
         stop_len  <= TW'(OSR);
         tx_done   <= 1'b1;
      end else if (!tx_en) begin
         state    <= ST_OFF;
         shreg    <= '1;
         tick_cnt <= '0;
      end else if (take) begin
         state     <= ST_SHIFT;
         shreg     <= frame;
         tick_cnt  <= '0;
         bits_left <= nbits;
         stop_len  <= stop_ticks;
         tx_done   <= 1'b0;
      end else begin
         unique case (state)
            ST_OFF: begin
               state     <= ST_SHIFT;
               shreg     <= '1;
               tick_cnt  <= '0;
               bits_left <= nbits;
               stop_len  <= stop_ticks;
               tx_done   <= 1'b0;
            end
            ST_IDLE: begin
               tick_cnt <= '0;
            end
            ST_SHIFT: begin
               if (bit_end) begin
                  tick_cnt <= '0;
                  shreg    <= {1'b1, shreg[FW-1:1]};
                  if (bits_left == BCW'(1)) begin
                     state <= ST_STOP;
                  end else begin
                     bits_left <= bits_left - BCW'(1);
                  end
               end else if (os_tick) begin
                  tick_cnt <= tick_cnt + TW'(1);
               end
            end
            ST_STOP: begin
               if (stop_end) begin
                  tick_cnt <= '0;
                  state    <= ST_IDLE;
                  tx_done  <= 1'b1;
               end else if (os_tick) begin
                  tick_cnt <= tick_cnt + TW'(1);
               end
            end
            default: state <= ST_OFF;
         endcase
      end
   end

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx #(
   parameter int DATA_W = 9,
   parameter int OSR    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              os_tick,
   input  logic              tx_en,
   input  logic              word9,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic [1:0]        stop_sel,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              clr_collide,
   output logic              tx_line,
   output logic              hold_empty,
   output logic              tx_done,
   output logic              wr_collide
);

   localparam int FW  = DATA_W + 1;
   localparam int TW  = $clog2(2 * OSR + 1);
   localparam int BCW = $clog2(FW + 1);

   if (DATA_W < 2) begin : g_bad_width
      $error("serial_frame_tx: DATA_W must be at least 2");
   end
   if ((OSR < 4) || ((OSR % 2) != 0)) begin : g_bad_osr
      $error("serial_frame_tx: OSR must be even and at least 4");
   end

   logic              hold_full;
   logic [DATA_W-1:0] hold_data;
   logic              take;
   logic [FW-1:0]     frame;
   logic [BCW-1:0]    nbits;
   logic [TW-1:0]     stop_ticks;

   sfx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_valid    (wr_valid),
      .wr_data     (wr_data),
      .take        (take),
      .clr_collide (clr_collide),
      .full        (hold_full),
      .data        (hold_data),
      .collide     (wr_collide)
   );

   sfx_framer #(
      .DATA_W (DATA_W),
      .OSR    (OSR),
      .FW     (FW),
      .TW     (TW),
      .BCW    (BCW)
   ) u_framer (
      .data       (hold_data),
      .word9      (word9),
      .par_en     (par_en),
      .par_odd    (par_odd),
      .stop_sel   (stop_sel),
      .frame      (frame),
      .nbits      (nbits),
      .stop_ticks (stop_ticks)
   );

   sfx_seq #(
      .OSR (OSR),
      .FW  (FW),
      .TW  (TW),
      .BCW (BCW)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .os_tick    (os_tick),
      .tx_en      (tx_en),
      .hold_full  (hold_full),
      .frame      (frame),
      .nbits      (nbits),
      .stop_ticks (stop_ticks),
      .take       (take),
      .tx_line    (tx_line),
      .tx_done    (tx_done)
   );

   assign hold_empty = !hold_full;

endmodule

// File: rtl/sfx_tx_checker.sv
module sfx_tx_checker (
   input logic clk,
   input logic rst_n,
   input logic tx_en,
   input logic wr_valid,
   input logic clr_collide,
   input logic tx_line,
   input logic hold_empty,
   input logic tx_done,
   input logic wr_collide
);

   // R1: a complete transmitter leaves the line at mark
   p_done_mark_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |-> tx_line);

   // R9: disabled transmitter drives mark on the following cycle
   p_off_mark_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> tx_line);

   // R6: accepted write makes the holding register non-empty
   p_write_fills_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && hold_empty) |=> !hold_empty);

   // R8: write into a full register raises the collision flag
   p_collide_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !hold_empty) |=> wr_collide);

   // R8: flag is sticky until cleared
   p_collide_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_collide && !clr_collide) |=> wr_collide);

   // R7: complete rises only when nothing was waiting
   p_done_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_done) |-> $past(hold_empty));

   // R2: a start bit never coexists with the complete flag
   p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_line) |-> !tx_done);

endmodule

bind serial_frame_tx sfx_tx_checker u_chk (.*);

// File: tb/tb_serial_frame_tx.sv
module tb_serial_frame_tx;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_en = 1'b0;
   logic       word9 = 1'b0;
   logic       par_en = 1'b0;
   logic       par_odd = 1'b0;
   logic [1:0] stop_sel = 2'b00;
   logic       wr_valid = 1'b0;
   logic [8:0] wr_data = '0;
   logic       clr_collide = 1'b0;
   logic       os_tick;
   logic       tx_line;
   logic       hold_empty;
   logic       tx_done;
   logic       wr_collide;

   int cyc = 0;
   int tick_count = 0;
   int n_run = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (os_tick) tick_count <= tick_count + 1;
   end
   assign os_tick = ((cyc % 3) == 2);

   serial_frame_tx dut (
      .clk (clk), .rst_n (rst_n), .os_tick (os_tick), .tx_en (tx_en),
      .word9 (word9), .par_en (par_en), .par_odd (par_odd),
      .stop_sel (stop_sel), .wr_valid (wr_valid), .wr_data (wr_data),
      .clr_collide (clr_collide), .tx_line (tx_line),
      .hold_empty (hold_empty), .tx_done (tx_done),
      .wr_collide (wr_collide)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int word_len();
      return word9 ? 9 : 8;
   endfunction

   function automatic int stop_len();
      case (stop_sel)
         2'b10:   return 32;
         2'b11:   return 24;
         default: return 16;
      endcase
   endfunction

   function automatic int frame_ticks();
      return (1 + word_len()) * 16 + stop_len();
   endfunction

   function automatic bit exp_bit(input logic [8:0] d, input int pos);
      int n = word_len();
      bit p = par_odd;
      if (pos == 0) return 1'b0;
      if (par_en && pos == n) begin
         for (int j = 0; j < n - 1; j++) p ^= d[j];
         return p;
      end
      return d[pos-1];
   endfunction

   task automatic wait_to(input int t0, input int k);
      while (tick_count - t0 < k) @(negedge clk);
   endtask

   task automatic write_word(input logic [8:0] d);
      @(negedge clk);
      wr_valid = 1'b1;
      wr_data  = d;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic pulse_clear();
      @(negedge clk);
      clr_collide = 1'b1;
      @(negedge clk);
      clr_collide = 1'b0;
   endtask

   task automatic find_start(output int t0);
      while (tx_line) @(negedge clk);
      t0 = tick_count;
   endtask

   task automatic check_bits(input int t0, input logic [8:0] d);
      for (int i = 0; i <= word_len(); i++) begin
         wait_to(t0, 16 * i + 8);
         if (par_en && i == word_len())
            chk(tx_line == exp_bit(d, i), "R3 parity bit", tx_line, exp_bit(d, i));
         else
            chk(tx_line == exp_bit(d, i), "R2 frame bit", tx_line, exp_bit(d, i));
      end
   endtask

   task automatic check_end(input int t0, input bit pending);
      int e = (1 + word_len()) * 16 + stop_len();
      wait_to(t0, e - 1);
      chk(tx_line == 1'b1, "R4 stop level", tx_line, 1);
      chk(tx_done == 1'b0, "R4 stop not over", tx_done, 0);
      wait_to(t0, e);
      if (pending) begin
         chk(tx_line == 1'b0, "R7 gapless next start", tx_line, 0);
         chk(tx_done == 1'b0, "R7 complete held low", tx_done, 0);
      end else begin
         chk(tx_done == 1'b1, "R7 complete at stop end", tx_done, 1);
         chk(tx_line == 1'b1, "R7 line idle", tx_line, 1);
      end
   endtask

   task automatic preamble(input bit pending);
      int t0;
      int lows = 0;
      int e = frame_ticks();
      @(negedge clk);
      while (os_tick) @(negedge clk);
      tx_en = 1'b1;
      t0 = tick_count;
      @(negedge clk);
      chk(tx_done == 1'b0, "R5 complete drops", tx_done, 0);
      while (tick_count - t0 < e - 1) begin
         if (!tx_line) lows++;
         @(negedge clk);
      end
      chk(lows == 0, "R5 idle frame high", lows, 0);
      chk(tx_done == 1'b0, "R5 idle frame length", tx_done, 0);
      wait_to(t0, e);
      if (pending)
         chk(tx_line == 1'b0, "R5 waiting char after idle frame", tx_line, 0);
      else
         chk(tx_done == 1'b1, "R5 idle frame end", tx_done, 1);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int t0;
      int t1;
      int lows;
      logic [8:0] d1;
      logic [8:0] d2;

      repeat (3) @(negedge clk);
      chk(tx_line == 1'b1, "R1 reset line", tx_line, 1);
      chk(hold_empty == 1'b1, "R1 reset empty", hold_empty, 1);
      chk(tx_done == 1'b1, "R1 reset complete", tx_done, 1);
      chk(wr_collide == 1'b0, "R1 reset collide", wr_collide, 0);
      rst_n = 1'b1;

      // R9: disabled transmitter holds a written character and stays quiet
      write_word(9'h0A5);
      chk(hold_empty == 1'b0, "R6 write clears empty", hold_empty, 0);
      lows = 0;
      repeat (200) begin
         @(negedge clk);
         if (!tx_line) lows++;
      end
      chk(lows == 0, "R9 no output while disabled", lows, 0);
      chk(hold_empty == 1'b0, "R9 character kept", hold_empty, 0);

      for (int cfg = 0; cfg < 32; cfg++) begin
         @(negedge clk);
         tx_en    = 1'b0;
         word9    = cfg[0];
         par_en   = cfg[1];
         par_odd  = cfg[2];
         stop_sel = cfg[4:3];
         @(negedge clk);
         if (cfg == 0) begin
            preamble(1'b1);
            find_start(t0);
            chk(hold_empty == 1'b1, "R6 empty on move", hold_empty, 1);
            check_bits(t0, 9'h0A5);
            check_end(t0, 1'b0);
         end else begin
            preamble(1'b0);
         end

         d1 = 9'(9'h1A5 ^ (cfg * 37));
         d2 = 9'(~d1 ^ (cfg << 2));
         write_word(d1);
         chk(hold_empty == 1'b0, "R6 write clears empty", hold_empty, 0);
         find_start(t0);
         chk(hold_empty == 1'b1, "R6 empty on move", hold_empty, 1);
         write_word(d2);
         if (cfg % 4 == 1) begin
            write_word(9'h1FF ^ d2);
            chk(wr_collide == 1'b1, "R8 collision flagged", wr_collide, 1);
            repeat (5) @(negedge clk);
            chk(wr_collide == 1'b1, "R8 collision sticky", wr_collide, 1);
            pulse_clear();
            chk(wr_collide == 1'b0, "R8 collision cleared", wr_collide, 0);
         end
         check_bits(t0, d1);
         check_end(t0, 1'b1);
         find_start(t1);
         check_bits(t1, d2);
         check_end(t1, 1'b0);
         lows = 0;
         repeat (120) begin
            @(negedge clk);
            if (!tx_line) lows++;
         end
         chk(lows == 0, "R8 dropped write never sent", lows, 0);
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule